// File: doc/BRIEF.md
# Vectored Nested-Priority Interrupt Controller

This block collects up to 32 interrupt sources and presents one active-low request line to a processor core. Each source has a mode word and a vector word. The mode word selects how the source is sensed and sets its 3-bit priority. The vector word is the value software receives when it acknowledges that source. Sensing is high level or rising edge for every source. Sources that are marked external at elaboration may also use low level or falling edge.

Software reads the acknowledge register to learn which source to serve. That read returns the vector of the winning source. On the same clock edge it pushes the winner onto an 8-entry nesting stack and clears the winner's edge latch. While a level is held, only a strictly higher priority can raise the request line again. Software writes the end-of-interrupt register to pop one level. A plain word-addressed register bus carries every access. Read data is combinational in the cycle of the access, and side effects take place on the clock edge that ends that cycle.

Top module: `vnic_top`

## Requirements
- R1: After reset, irq_n is 1, the enable mask reads 0, the status register reads 0, the edge-latch register reads 0, and an acknowledge read returns the spurious vector, which resets to 0.
- R2: Writing the enable-set register (word address 0x43) enables each source whose data bit is 1. Writing the enable-clear register (0x44) disables each source whose data bit is 1. Zero bits leave their sources unchanged, and an all-ones write to 0x44 disables every source. The mask reads back at 0x45.
- R3: Writing the latch-clear register (0x46) clears the edge latch of each source whose data bit is 1 and leaves the others alone. An all-ones write clears every latch. The latches read back at 0x48.
- R4: The mode word of source i is at word address i. Its sense type sits in bits [1:0] (0 high level, 1 rising edge, 2 low level, 3 falling edge) and its priority in bits [6:4]. A mode write that gives an internal source type 2 or 3 updates the priority but keeps the old type.
- R5: An edge-sensed source sets its latch on the selected edge, and the acknowledge that serves it clears the latch. A level-sensed source is never latched and follows its live input.
- R6: The winner among enabled, active sources is the one with the highest priority (7 is highest). When priorities are equal, the lowest source number wins.
- R7: When the winner's priority is above the current level, an acknowledge read (0x40) returns the winner's vector word (word address 0x20 + i) and adds one nesting level. Otherwise it returns the spurious vector (0x42) and leaves the nesting unchanged.
- R8: While a level is held, irq_n goes low only for a source whose priority is strictly greater than the priority on top of the nesting stack.
- R9: The status register (0x41) reads 0 when no level is held or when the last acknowledge was spurious. Otherwise it reads the source number on top of the nesting stack.
- R10: Each write to the end-of-interrupt register (0x47) pops one level, whatever the data. A write with nothing held has no effect, so eight such writes always return the block to idle.
- R11: irq_n is 0 exactly when some enabled, active source has a priority above the current level. It returns to 1 right after the edge of the acknowledge that serves the last such source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Raw interrupt source inputs |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the access |
| irq_n | output | 1 | Active-low interrupt request to the core |

## Verification
The bench builds the block with its defaults: 32 sources, 3-bit priorities, an 8-entry stack and 32-bit vectors. Sources 28 to 31 are marked external. Because the stack is exactly as deep as the number of priority levels, one directed run can push a full eight-level chain using sources 10 to 17 at priorities 0 to 7. That run then unwinds the chain with eight end-of-interrupt writes. With external sources in the mask, the bench can drive falling-edge and low-level sensing on real pins. It can also confirm that an internal source rejects those two types.

// File: rtl/vnic_pkg.sv
package vnic_pkg;
   typedef enum logic [1:0] {
      SENSE_HIGH = 2'd0,
      SENSE_RISE = 2'd1,
      SENSE_LOW  = 2'd2,
      SENSE_FALL = 2'd3
   } sense_e;

   localparam int unsigned MODE_PRIO_LSB = 4;

   localparam logic [7:0] ADR_MODE_BASE = 8'h00;
   localparam logic [7:0] ADR_VEC_BASE  = 8'h20;
   localparam logic [7:0] ADR_ACK       = 8'h40;
   localparam logic [7:0] ADR_STATUS    = 8'h41;
   localparam logic [7:0] ADR_SPUR      = 8'h42;
   localparam logic [7:0] ADR_EN_SET    = 8'h43;
   localparam logic [7:0] ADR_EN_CLR    = 8'h44;
   localparam logic [7:0] ADR_EN_RD     = 8'h45;
   localparam logic [7:0] ADR_LATCH_CLR = 8'h46;
   localparam logic [7:0] ADR_EOI       = 8'h47;
   localparam logic [7:0] ADR_LATCH_RD  = 8'h48;
endpackage

// File: rtl/vnic_detect.sv
module vnic_detect
   import vnic_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter logic [NUM_SRC-1:0] EXT_MASK = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   src_i,
   input  logic [2*NUM_SRC-1:0] sense_i,
   input  logic [NUM_SRC-1:0]   clr_i,
   output logic [NUM_SRC-1:0]   active_o,
   output logic [NUM_SRC-1:0]   latch_o
);
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic       prev_q;
      logic       latch_q;
      logic [1:0] sense;
      logic       rise;
      logic       fall;
      logic       is_edge;
      logic       edge_hit;
      logic       lvl;

      assign sense   = sense_i[2*g +: 2];
      assign rise    = src_i[g] & ~prev_q;
      assign fall    = ~src_i[g] & prev_q;
      assign is_edge = sense[0];

      if (EXT_MASK[g]) begin : g_ext
         assign edge_hit = (sense == SENSE_RISE && rise) || (sense == SENSE_FALL && fall);
         assign lvl      = (sense == SENSE_HIGH) ? src_i[g] :
                           (sense == SENSE_LOW)  ? ~src_i[g] : 1'b0;
      end else begin : g_int
         assign edge_hit = is_edge & rise;
         assign lvl      = ~is_edge & src_i[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
         end else begin
            prev_q <= src_i[g];
            if (!is_edge)      latch_q <= 1'b0;
            else if (edge_hit) latch_q <= 1'b1;
            else if (clr_i[g]) latch_q <= 1'b0;
         end
      end

      assign active_o[g] = is_edge ? latch_q : lvl;
      assign latch_o[g]  = latch_q;

      // R5
      edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_hit && is_edge) |=> (latch_q || !is_edge));
   end
endmodule

// File: rtl/vnic_arb.sv
module vnic_arb #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned PRIO_W  = 3,
   localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]        req_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   output logic                      valid_o,
   output logic [IDX_W-1:0]          idx_o,
   output logic [PRIO_W-1:0]         prio_o
);
   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      prio_o  = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
            valid_o = 1'b1;
            idx_o   = IDX_W'(i);
            prio_o  = prio_i[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/vnic_stack.sv
module vnic_stack #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned PRIO_W = 3,
   parameter int unsigned IDX_W  = 5,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [PRIO_W-1:0] push_prio_i,
   input  logic [IDX_W-1:0]  push_idx_i,
   input  logic              pop_i,
   output logic              empty_o,
   output logic              full_o,
   output logic [PRIO_W-1:0] top_prio_o,
   output logic [IDX_W-1:0]  top_idx_o,
   output logic [CNT_W-1:0]  depth_o
);
   logic [PRIO_W-1:0] prio_mem [DEPTH];
   logic [IDX_W-1:0]  idx_mem  [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic [PTR_W-1:0]  top_ptr;
   logic [PTR_W-1:0]  wr_ptr;

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CNT_W'(DEPTH));
   assign top_ptr = empty_o ? '0 : PTR_W'(cnt_q - 1'b1);
   assign wr_ptr  = PTR_W'(cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            prio_mem[i] <= '0;
            idx_mem[i]  <= '0;
         end
      end else if (push_i && !full_o) begin
         prio_mem[wr_ptr] <= push_prio_i;
         idx_mem[wr_ptr]  <= push_idx_i;
         cnt_q            <= cnt_q + 1'b1;
      end else if (pop_i && !empty_o) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign top_prio_o = prio_mem[top_ptr];
   assign top_idx_o  = idx_mem[top_ptr];
   assign depth_o    = cnt_q;

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   // R8
   push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !empty_o) |-> (push_prio_i > top_prio_o));
   // R10
   one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));
endmodule

// File: rtl/vnic_top.sv
module vnic_top
   import vnic_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 32,
   parameter int unsigned PRIO_W     = 3,
   parameter int unsigned NEST_DEPTH = 8,
   parameter int unsigned VEC_W      = 32,
   parameter int unsigned DATA_W     = 32,
   parameter logic [NUM_SRC-1:0] EXT_MASK = 32'hF000_0000,
   localparam int unsigned IDX_W = $clog2(NUM_SRC),
   localparam int unsigned CNT_W = $clog2(NEST_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [7:0]         bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_n
);
   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_src
      $error("vnic_top: NUM_SRC must be 2..32");
   end
   if (NEST_DEPTH < (1 << PRIO_W)) begin : g_bad_depth
      $error("vnic_top: NEST_DEPTH must cover every priority level");
   end
   if (DATA_W < VEC_W || DATA_W < NUM_SRC || DATA_W < MODE_PRIO_LSB + PRIO_W) begin : g_bad_data
      $error("vnic_top: DATA_W too narrow");
   end

   logic [NUM_SRC-1:0]        en_q;
   logic [VEC_W-1:0]          spur_q;
   logic [VEC_W-1:0]          vec_q   [NUM_SRC];
   logic [1:0]                sense_q [NUM_SRC];
   logic [PRIO_W-1:0]         prio_q  [NUM_SRC];
   logic                      spur_flag_q;

   logic [2*NUM_SRC-1:0]      sense_flat;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic [NUM_SRC-1:0]        active;
   logic [NUM_SRC-1:0]        latch;
   logic [NUM_SRC-1:0]        clr_mask;
   logic [NUM_SRC-1:0]        ack_onehot;
   logic                      win_valid;
   logic [IDX_W-1:0]          win_idx;
   logic [PRIO_W-1:0]         win_prio;
   logic                      stk_empty;
   logic                      stk_full;
   logic [PRIO_W-1:0]         top_prio;
   logic [IDX_W-1:0]          top_idx;
   logic [CNT_W-1:0]          depth;

   logic wr_en, rd_en, mode_hit, vec_hit, ack_rd, push, pop, eoi_wr, qualify;
   logic [IDX_W-1:0] reg_idx;

   assign wr_en    = bus_sel & bus_wr;
   assign rd_en    = bus_sel & ~bus_wr;
   assign reg_idx  = bus_addr[IDX_W-1:0];
   assign mode_hit = (bus_addr[7:5] == ADR_MODE_BASE[7:5]) && (int'(reg_idx) < NUM_SRC);
   assign vec_hit  = (bus_addr[7:5] == ADR_VEC_BASE[7:5])  && (int'(reg_idx) < NUM_SRC);
   assign ack_rd   = rd_en && (bus_addr == ADR_ACK);
   assign eoi_wr   = wr_en && (bus_addr == ADR_EOI);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_flat
      assign sense_flat[2*g +: 2]         = sense_q[g];
      assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
   end

   assign qualify    = win_valid && (stk_empty || win_prio > top_prio);
   assign push       = ack_rd && qualify;
   assign pop        = eoi_wr && !stk_empty;
   assign ack_onehot = push ? (NUM_SRC'(1) << win_idx) : '0;
   assign clr_mask   = ack_onehot |
                       ((wr_en && bus_addr == ADR_LATCH_CLR) ? bus_wdata[NUM_SRC-1:0] : '0);

   vnic_detect #(.NUM_SRC(NUM_SRC), .EXT_MASK(EXT_MASK)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_i),
      .sense_i  (sense_flat),
      .clr_i    (clr_mask),
      .active_o (active),
      .latch_o  (latch)
   );

   vnic_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .req_i   (active & en_q),
      .prio_i  (prio_flat),
      .valid_o (win_valid),
      .idx_o   (win_idx),
      .prio_o  (win_prio)
   );

   vnic_stack #(.DEPTH(NEST_DEPTH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .push_prio_i (win_prio),
      .push_idx_i  (win_idx),
      .pop_i       (pop),
      .empty_o     (stk_empty),
      .full_o      (stk_full),
      .top_prio_o  (top_prio),
      .top_idx_o   (top_idx),
      .depth_o     (depth)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q        <= '0;
         spur_q      <= '0;
         spur_flag_q <= 1'b0;
         for (int i = 0; i < NUM_SRC; i++) begin
            vec_q[i]   <= '0;
            sense_q[i] <= SENSE_HIGH;
            prio_q[i]  <= '0;
         end
      end else begin
         if (wr_en && bus_addr == ADR_EN_SET) en_q <= en_q | bus_wdata[NUM_SRC-1:0];
         if (wr_en && bus_addr == ADR_EN_CLR) en_q <= en_q & ~bus_wdata[NUM_SRC-1:0];
         if (wr_en && bus_addr == ADR_SPUR)   spur_q <= bus_wdata[VEC_W-1:0];
         if (push || eoi_wr)                  spur_flag_q <= 1'b0;
         else if (ack_rd)                     spur_flag_q <= 1'b1;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (wr_en && mode_hit && reg_idx == IDX_W'(i)) begin
               prio_q[i] <= bus_wdata[MODE_PRIO_LSB +: PRIO_W];
               if (EXT_MASK[i] || !bus_wdata[1]) sense_q[i] <= bus_wdata[1:0];
            end
            if (wr_en && vec_hit && reg_idx == IDX_W'(i)) vec_q[i] <= bus_wdata[VEC_W-1:0];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (mode_hit) begin
         bus_rdata[MODE_PRIO_LSB +: PRIO_W] = prio_q[reg_idx];
         bus_rdata[1:0]                     = sense_q[reg_idx];
      end else if (vec_hit) begin
         bus_rdata[VEC_W-1:0] = vec_q[reg_idx];
      end else begin
         case (bus_addr)
            ADR_ACK:      bus_rdata[VEC_W-1:0] = qualify ? vec_q[win_idx] : spur_q;
            ADR_STATUS:   bus_rdata[IDX_W-1:0] = (stk_empty || spur_flag_q) ? '0 : top_idx;
            ADR_SPUR:     bus_rdata[VEC_W-1:0] = spur_q;
            ADR_EN_RD:    bus_rdata[NUM_SRC-1:0] = en_q;
            ADR_LATCH_RD: bus_rdata[NUM_SRC-1:0] = latch;
            default:      bus_rdata = '0;
         endcase
      end
   end

   assign irq_n = ~qualify;

   // R7
   ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (depth == $past(depth) + 1'b1));
   // R7
   spur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !qualify) |=> $stable(depth));
   // R10
   eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (depth == $past(depth) - 1'b1));
   // R6
   win_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (active[win_idx] && en_q[win_idx]));
   // R11
   irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (en_q != '0));
   // R10
   full_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_full |-> (top_prio == {PRIO_W{1'b1}}));
endmodule

// File: tb/vnic_top_tb_top.sv
module vnic_top_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   vnic_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_n     (irq_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic set_src(input int i, input logic v);
      @(negedge clk);
      src[i] = v;
      @(negedge clk);
   endtask

   task automatic cleanup();
      src = '0;
      bwr(8'h44, 32'hFFFF_FFFF);
      bwr(8'h46, 32'hFFFF_FFFF);
      for (int k = 0; k < 8; k++) bwr(8'h47, 32'h0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 irq_n", {31'b0, irq_n}, 32'h1);
      brd(8'h45, d); chk("R1 enable", d, 32'h0);
      brd(8'h41, d); chk("R1 status", d, 32'h0);
      brd(8'h48, d); chk("R1 latch", d, 32'h0);
      brd(8'h40, d); chk("R1 ack spurious", d, 32'h0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      bwr(8'h43, 32'h0000_00FF);
      bwr(8'h43, 32'h0000_0100);
      brd(8'h45, d); chk("R2 set keeps zeros", d, 32'h0000_01FF);
      bwr(8'h44, 32'h0000_000F);
      brd(8'h45, d); chk("R2 clear", d, 32'h0000_01F0);
      bwr(8'h44, 32'hFFFF_FFFF);
      brd(8'h45, d); chk("R2 clear all", d, 32'h0);
   endtask

   task automatic t_mode();
      logic [31:0] d;
      bwr(8'h03, 32'h50);
      brd(8'h03, d); chk("R4 mode readback", d, 32'h50);
      bwr(8'h03, (d & ~32'h3) | 32'h1);
      brd(8'h03, d); chk("R4 rmw keeps prio", d, 32'h51);
      bwr(8'h03, 32'h62);
      brd(8'h03, d); chk("R4 internal rejects low", d, 32'h61);
      bwr(8'h1E, 32'h73);
      brd(8'h1E, d); chk("R4 external falling", d, 32'h73);
   endtask

   task automatic t_spurious();
      logic [31:0] d;
      bwr(8'h42, 32'h0000_DEAD);
      brd(8'h40, d); chk("R7 spurious vector", d, 32'h0000_DEAD);
      brd(8'h41, d); chk("R9 status idle", d, 32'h0);
      chk("R11 idle irq_n", {31'b0, irq_n}, 32'h1);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      bwr(8'h02, 32'h21);
      bwr(8'h43, 32'h4);
      set_src(2, 1'b1);
      set_src(2, 1'b0);
      chk("R5 rising latched irq", {31'b0, irq_n}, 32'h0);
      brd(8'h48, d); chk("R5 latch bit", d, 32'h4);
      brd(8'h40, d); chk("R7 ack vector", d, 32'h102);
      chk("R11 irq released", {31'b0, irq_n}, 32'h1);
      brd(8'h48, d); chk("R5 latch cleared by ack", d, 32'h0);
      brd(8'h41, d); chk("R9 status source", d, 32'h2);
      brd(8'h40, d); chk("R7 nothing higher", d, 32'h0000_DEAD);
      brd(8'h41, d); chk("R9 status after spurious", d, 32'h0);
      bwr(8'h47, 32'h1234_5678);
      brd(8'h40, d); chk("R10 popped then idle", d, 32'h0000_DEAD);
      cleanup();
   endtask

   task automatic t_latch_clear();
      logic [31:0] d;
      bwr(8'h43, 32'hC);
      set_src(2, 1'b1); set_src(2, 1'b0);
      chk("R3 pending irq", {31'b0, irq_n}, 32'h0);
      bwr(8'h46, 32'h4);
      chk("R3 cleared irq", {31'b0, irq_n}, 32'h1);
      set_src(2, 1'b1); set_src(2, 1'b0);
      set_src(3, 1'b1); set_src(3, 1'b0);
      brd(8'h48, d); chk("R3 two latched", d, 32'hC);
      bwr(8'h46, 32'h8);
      brd(8'h48, d); chk("R3 zero bits kept", d, 32'h4);
      bwr(8'h46, 32'hFFFF_FFFF);
      brd(8'h48, d); chk("R3 clear all", d, 32'h0);
      cleanup();
   endtask

   task automatic t_level();
      logic [31:0] d;
      bwr(8'h04, 32'h10);
      bwr(8'h43, 32'h10);
      set_src(4, 1'b1);
      chk("R5 level active", {31'b0, irq_n}, 32'h0);
      set_src(4, 1'b0);
      chk("R5 level follows input", {31'b0, irq_n}, 32'h1);
      brd(8'h48, d); chk("R5 level not latched", d, 32'h0);
      cleanup();
   endtask

   task automatic t_arb();
      logic [31:0] d;
      bwr(8'h05, 32'h30); bwr(8'h06, 32'h30); bwr(8'h07, 32'h10);
      bwr(8'h09, 32'h60);
      bwr(8'h43, 32'hE0);
      src[5] = 1'b1; src[6] = 1'b1; src[7] = 1'b1;
      @(negedge clk);
      chk("R11 request", {31'b0, irq_n}, 32'h0);
      brd(8'h40, d); chk("R6 tie lowest index", d, 32'h105);
      brd(8'h41, d); chk("R9 status 5", d, 32'h5);
      chk("R8 equal prio blocked", {31'b0, irq_n}, 32'h1);
      bwr(8'h43, 32'h200);
      set_src(9, 1'b1);
      chk("R8 higher preempts", {31'b0, irq_n}, 32'h0);
      brd(8'h40, d); chk("R6 highest prio", d, 32'h109);
      brd(8'h41, d); chk("R9 status 9", d, 32'h9);
      set_src(9, 1'b0);
      bwr(8'h47, 32'h0);
      brd(8'h41, d); chk("R10 back to 5", d, 32'h5);
      chk("R8 equal still blocked", {31'b0, irq_n}, 32'h1);
      bwr(8'h47, 32'hFFFF_FFFF);
      chk("R11 idle re-requests", {31'b0, irq_n}, 32'h0);
      cleanup();
   endtask

   task automatic t_nest();
      logic [31:0] d;
      for (int k = 0; k < 8; k++) begin
         bwr(8'(10 + k), 32'(k << 4));
         bwr(8'h43, 32'(1) << (10 + k));
         set_src(10 + k, 1'b1);
         chk("R8 next level irq", {31'b0, irq_n}, 32'h0);
         brd(8'h40, d); chk("R7 nested vector", d, 32'(32'h100 + 10 + k));
      end
      brd(8'h41, d); chk("R9 top of eight", d, 32'd17);
      chk("R8 full blocks", {31'b0, irq_n}, 32'h1);
      src = '0;
      for (int k = 0; k < 7; k++) bwr(8'h47, 32'(k * 3));
      brd(8'h41, d); chk("R10 seven pops", d, 32'd10);
      bwr(8'h47, 32'hA5A5_A5A5);
      brd(8'h41, d); chk("R10 eight pops idle", d, 32'h0);
      bwr(8'h47, 32'h0);
      brd(8'h40, d); chk("R10 empty eoi harmless", d, 32'h0000_DEAD);
      chk("R11 idle", {31'b0, irq_n}, 32'h1);
      cleanup();
   endtask

   task automatic t_external();
      logic [31:0] d;
      set_src(29, 1'b1);
      bwr(8'h1D, 32'h43);
      bwr(8'h43, 32'h2000_0000);
      chk("R5 falling idle", {31'b0, irq_n}, 32'h1);
      set_src(29, 1'b0);
      chk("R5 falling latched", {31'b0, irq_n}, 32'h0);
      brd(8'h40, d); chk("R7 external vector", d, 32'h11D);
      brd(8'h48, d); chk("R5 falling latch cleared", d, 32'h0);
      bwr(8'h47, 32'h0);
      set_src(30, 1'b1);
      bwr(8'h1E, 32'h52);
      bwr(8'h43, 32'h4000_0000);
      chk("R4 low level inactive", {31'b0, irq_n}, 32'h1);
      set_src(30, 1'b0);
      chk("R4 low level active", {31'b0, irq_n}, 32'h0);
      set_src(30, 1'b1);
      chk("R4 low level released", {31'b0, irq_n}, 32'h1);
      cleanup();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      for (int i = 0; i < 32; i++) bwr(8'(8'h20 + i), 32'(32'h100 + i));
      t_enable();
      t_mode();
      t_spurious();
      t_edge();
      t_latch_clear();
      t_level();
      t_arb();
      t_nest();
      t_external();
      finish_run();
   end

   initial begin
      #(CLK_P * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule